// File: doc/BRIEF.md
# Privilege Mode and Access Flag Unit

This block decides which of three privilege levels (kernel, supervisor, user) a processor core is running in. It also produces the access enables that the rest of the pipeline consults: coprocessor-0 access, floating-point access and 64-bit addressing. It holds a masked copy of the processor status word, together with a debug-mode flag. Software writes reach that copy through a write strobe and a write mask. Three hardware events change it: general exception entry, reset/NMI entry and debug entry.

The exception level, error level and debug state each force kernel mode, whatever the mode bits hold. When both the user bit and the supervisor bit are set, the combination is reserved and resolves to user, so the mode code stays one-hot. The flags are registered one stage after the status copy and the debug flag. Reset/NMI entry also pulses a PC-load strobe that carries the reset vector.

Top module: `pmode_unit`

## Requirements
- R1: After reset, the status copy is 0x00400004 (ERL and BEV set), debug is 0, the mode is kernel, CP0 access is 1, FPU access is 0, 64-bit addressing is 1 and pc_load_o is 0.
- R2: The mode is user (code 3'b100) when status bit 4 (UM) is 1, and bit 1 (EXL), bit 2 (ERL) and the debug flag are all 0.
- R3: The mode is supervisor (code 3'b010) when status bit 3 is 1, bit 4 is 0, and EXL, ERL and debug are all 0. When bits 3 and 4 are both 1, the mode is user.
- R4: In every other case the mode is kernel (code 3'b001). The mode code is always exactly one-hot.
- R5: CP0 access is 1 when status bit 28 (CU0) is 1 or the mode is kernel.
- R6: FPU access equals status bit 29 (CU1).
- R7: 64-bit addressing is 1 when the mode is not user, or when status bit 23 (PX) or bit 5 (UX) is 1.
- R8: A status write replaces only the bits set in the write mask (default 0x3678FF1F, which includes bit 3). All other bits never change.
- R9: Exception entry sets bit 1 (EXL). Reset/NMI entry sets bit 2 (ERL) and bit 22 (BEV), and pulses pc_load_o for one cycle with pc_vec_o = 0xBFC00000. Debug entry sets the debug flag and debug return clears it. Any of the three entries gives kernel mode with CP0 access and 64-bit addressing.
- R10: The status copy and the debug flag change at the clock edge that samples the strobe. The mode and flags change at the following edge.
- R11: Any exception or reset/NMI strobe blocks a status write in the same cycle. Reset/NMI entry blocks exception entry, so EXL stays unchanged. Debug entry wins over a simultaneous debug return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_we_i | input | 1 | Status write strobe |
| status_wdata_i | input | 32 | Status write data |
| exc_entry_i | input | 1 | General exception entry strobe |
| err_entry_i | input | 1 | Reset/NMI entry strobe |
| dbg_entry_i | input | 1 | Debug entry strobe |
| dbg_ret_i | input | 1 | Debug return strobe |
| status_o | output | 32 | Current status copy |
| dbg_mode_o | output | 1 | Debug mode flag |
| mode_o | output | 3 | One-hot mode: 001 kernel, 010 supervisor, 100 user |
| cp0_en_o | output | 1 | Coprocessor-0 access enable |
| fpu_en_o | output | 1 | FPU access enable |
| a64_en_o | output | 1 | 64-bit addressing enable |
| pc_load_o | output | 1 | Reset-vector PC load pulse |
| pc_vec_o | output | 32 | Reset vector value |

## Verification
The assertions check the following on every cycle:
- the mode is one-hot;
- user mode only follows a user-permitting status and debug state;
- kernel mode brings CP0 access;
- bits outside the mask never move;
- each entry event sets its status bits, blocks a write and leads to kernel mode two edges later.

The exact masked merge of write data, the reserved UM+R0 encoding and the one-edge lag of the flags can only be shown by the bench. It sets up those scenarios and compares against its own reference model on every clock. The same holds for the precedence among simultaneous strobes and for the return to user or supervisor after debug exit.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_R0  = 3;
  localparam int ST_UM  = 4;
  localparam int ST_UX  = 5;
  localparam int ST_BEV = 22;
  localparam int ST_PX  = 23;
  localparam int ST_CU0 = 28;
  localparam int ST_CU1 = 29;

  typedef enum logic [2:0] {
    MODE_KERNEL = 3'b001,
    MODE_SUPER  = 3'b010,
    MODE_USER   = 3'b100
  } pmode_e;

  typedef struct packed {
    pmode_e mode;
    logic   cp0_en;
    logic   fpu_en;
    logic   a64_en;
  } pflags_t;

  localparam pflags_t FLAGS_RST = '{mode: MODE_KERNEL, cp0_en: 1'b1, fpu_en: 1'b0, a64_en: 1'b1};
endpackage

// File: rtl/pmode_status_reg.sv
module pmode_status_reg
  import pmode_pkg::*;
#(
  parameter int           W       = 32,
  parameter logic [W-1:0] WMASK   = 32'h3678_FF1F,
  parameter logic [W-1:0] RST_VAL = 32'h0040_0004
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         exc_i,
  input  logic         err_i,
  output logic [W-1:0] status_o
);
  localparam logic [W-1:0] ERR_SET = (W'(1) << ST_ERL) | (W'(1) << ST_BEV);
  localparam logic [W-1:0] EXC_SET = W'(1) << ST_EXL;

  logic [W-1:0] st_q;

  // events outrank software writes; reset/NMI outranks exception
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= RST_VAL;
    else if (err_i) st_q <= st_q | ERR_SET;
    else if (exc_i) st_q <= st_q | EXC_SET;
    else if (we_i)  st_q <= (wdata_i & WMASK) | (st_q & ~WMASK);
  end

  assign status_o = st_q;

  p_ro_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(st_q & ~WMASK));
  p_err_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> (st_q[ST_ERL] && st_q[ST_BEV]));
  p_exc_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i && !err_i) |=> st_q[ST_EXL]);
  p_err_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> (((st_q ^ $past(st_q)) & ~ERR_SET) == '0));
  p_exc_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i && !err_i) |=> (((st_q ^ $past(st_q)) & ~EXC_SET) == '0));
endmodule

// File: rtl/pmode_dbg_flag.sv
module pmode_dbg_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic entry_i,
  input  logic ret_i,
  output logic dbg_o
);
  logic dbg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dbg_q <= 1'b0;
    else if (entry_i) dbg_q <= 1'b1;
    else if (ret_i)   dbg_q <= 1'b0;
  end

  assign dbg_o = dbg_q;

  p_dbg_entry_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i |=> dbg_q);
  p_dbg_ret_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !entry_i) |=> !dbg_q);
endmodule

// File: rtl/pmode_decode.sv
module pmode_decode
  import pmode_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] status_i,
  input  logic         dbg_i,
  output pflags_t      flags_o
);
  logic   base_ok;
  pmode_e mode;

  assign base_ok = !status_i[ST_EXL] && !status_i[ST_ERL] && !dbg_i;

  // UM+R0 together is reserved: user wins
  always_comb begin
    mode = MODE_KERNEL;
    if (base_ok && status_i[ST_UM])      mode = MODE_USER;
    else if (base_ok && status_i[ST_R0]) mode = MODE_SUPER;
  end

  always_comb begin
    flags_o.mode   = mode;
    flags_o.cp0_en = status_i[ST_CU0] || (mode == MODE_KERNEL);
    flags_o.fpu_en = status_i[ST_CU1];
    flags_o.a64_en = (mode != MODE_USER) || status_i[ST_PX] || status_i[ST_UX];
  end
endmodule

// File: rtl/pmode_flag_reg.sv
module pmode_flag_reg
  import pmode_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  pflags_t flags_d,
  output pflags_t flags_q
);
  pflags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= FLAGS_RST;
    else         q <= flags_d;
  end

  assign flags_q = q;

  p_mode_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(q.mode) == 1);
  p_kernel_cp0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q.mode == MODE_KERNEL) |-> q.cp0_en);
  p_kernel_a64_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q.mode != MODE_USER) |-> q.a64_en);
endmodule

// File: rtl/pmode_unit.sv
module pmode_unit
  import pmode_pkg::*;
#(
  parameter int           W         = 32,
  parameter logic [W-1:0] WMASK     = 32'h3678_FF1F,
  parameter logic [W-1:0] RST_VAL   = 32'h0040_0004,
  parameter logic [W-1:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         status_we_i,
  input  logic [W-1:0] status_wdata_i,
  input  logic         exc_entry_i,
  input  logic         err_entry_i,
  input  logic         dbg_entry_i,
  input  logic         dbg_ret_i,
  output logic [W-1:0] status_o,
  output logic         dbg_mode_o,
  output logic [2:0]   mode_o,
  output logic         cp0_en_o,
  output logic         fpu_en_o,
  output logic         a64_en_o,
  output logic         pc_load_o,
  output logic [W-1:0] pc_vec_o
);
  logic [W-1:0] status;
  logic         dbg;
  pflags_t      flags_d, flags_q;
  logic         pc_load_q;

  pmode_status_reg #(.W(W), .WMASK(WMASK), .RST_VAL(RST_VAL)) u_status (
    .clk_i, .rst_ni,
    .we_i(status_we_i), .wdata_i(status_wdata_i),
    .exc_i(exc_entry_i), .err_i(err_entry_i),
    .status_o(status)
  );

  pmode_dbg_flag u_dbg (
    .clk_i, .rst_ni,
    .entry_i(dbg_entry_i), .ret_i(dbg_ret_i),
    .dbg_o(dbg)
  );

  pmode_decode #(.W(W)) u_dec (
    .status_i(status), .dbg_i(dbg), .flags_o(flags_d)
  );

  pmode_flag_reg u_flags (
    .clk_i, .rst_ni, .flags_d(flags_d), .flags_q(flags_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_load_q <= 1'b0;
    else         pc_load_q <= err_entry_i;
  end

  assign status_o   = status;
  assign dbg_mode_o = dbg;
  assign mode_o     = flags_q.mode;
  assign cp0_en_o   = flags_q.cp0_en;
  assign fpu_en_o   = flags_q.fpu_en;
  assign a64_en_o   = flags_q.a64_en;
  assign pc_load_o  = pc_load_q;
  assign pc_vec_o   = RESET_VEC;

  p_user_cond_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_USER) |-> $past(status[ST_UM] && !status[ST_EXL] && !status[ST_ERL] && !dbg));
  p_event_kernel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_entry_i || err_entry_i || dbg_entry_i) |=> ##1 (mode_o == MODE_KERNEL && cp0_en_o && a64_en_o));
  p_pc_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_entry_i |=> pc_load_o);
endmodule

// File: tb/pmode_unit_test.sv
`timescale 1ns/1ps
module pmode_unit_test;
  localparam logic [31:0] MASK = 32'h3678_FF1F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, exc = 1'b0, err = 1'b0, dent = 1'b0, dret = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] status_o, pc_vec_o;
  logic        dbg_mode_o, cp0_en_o, fpu_en_o, a64_en_o, pc_load_o;
  logic [2:0]  mode_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmode_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .status_we_i(we), .status_wdata_i(wd),
    .exc_entry_i(exc), .err_entry_i(err),
    .dbg_entry_i(dent), .dbg_ret_i(dret),
    .status_o, .dbg_mode_o, .mode_o, .cp0_en_o, .fpu_en_o, .a64_en_o,
    .pc_load_o, .pc_vec_o
  );

  // reference model
  logic [31:0] m_st = 32'h0040_0004;
  logic        m_dbg = 0, m_pc = 0, m_cp0 = 1, m_fpu = 0, m_a64 = 1;
  logic [2:0]  m_mode = 3'b001;

  function automatic logic [2:0] ref_mode(logic [31:0] s, logic d);
    if (s[1] || s[2] || d) return 3'b001;
    if (s[4]) return 3'b100;
    if (s[3]) return 3'b010;
    return 3'b001;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 32'h0040_0004; m_dbg = 0; m_pc = 0;
      m_mode = 3'b001; m_cp0 = 1; m_fpu = 0; m_a64 = 1;
    end else begin
      m_mode = ref_mode(m_st, m_dbg);
      m_cp0  = m_st[28] || (m_mode == 3'b001);
      m_fpu  = m_st[29];
      m_a64  = (m_mode != 3'b100) || m_st[23] || m_st[5];
      m_pc   = err;
      if (err)      m_st = m_st | 32'h0040_0004;
      else if (exc) m_st = m_st | 32'h0000_0002;
      else if (we)  m_st = (wd & MASK) | (m_st & ~MASK);
      if (dent)      m_dbg = 1;
      else if (dret) m_dbg = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 mode", {29'd0, mode_o}, {29'd0, m_mode});
      chk("R5 cp0", {31'd0, cp0_en_o}, {31'd0, m_cp0});
      chk("R6 fpu", {31'd0, fpu_en_o}, {31'd0, m_fpu});
      chk("R7 a64", {31'd0, a64_en_o}, {31'd0, m_a64});
      chk("R8 status", status_o, m_st);
      chk("R9 dbg", {31'd0, dbg_mode_o}, {31'd0, m_dbg});
      chk("R9 pc_load", {31'd0, pc_load_o}, {31'd0, m_pc});
    end
  end

  task automatic drive(logic w, logic [31:0] d, logic e, logic r, logic de, logic dr);
    we = w; wd = d; exc = e; err = r; dent = de; dret = dr;
    @(negedge clk);
    we = 0; exc = 0; err = 0; dent = 0; dret = 0;
  endtask

  task automatic idle(); @(negedge clk); endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status_o, 32'h0040_0004);
    chk("R1 mode", {29'd0, mode_o}, 32'd1);
    chk("R1 flags", {28'd0, cp0_en_o, fpu_en_o, a64_en_o, pc_load_o}, 32'b1010);
    chk("R1 dbg", {31'd0, dbg_mode_o}, 32'd0);
    rst_n = 1;
    idle();

    drive(1, 32'h10, 0, 0, 0, 0);
    chk("R10 status first", status_o, 32'h10);
    chk("R10 mode lags", {29'd0, mode_o}, 32'd1);
    idle();
    chk("R2 user", {29'd0, mode_o}, 32'd4);
    chk("R5 cp0 user", {31'd0, cp0_en_o}, 32'd0);
    chk("R7 a64 user", {31'd0, a64_en_o}, 32'd0);

    drive(1, 32'h8, 0, 0, 0, 0); idle();
    chk("R3 super", {29'd0, mode_o}, 32'd2);
    chk("R7 a64 super", {31'd0, a64_en_o}, 32'd1);

    drive(1, 32'h18, 0, 0, 0, 0); idle();
    chk("R3 reserved user", {29'd0, mode_o}, 32'd4);

    drive(1, 32'h3000_0010, 0, 0, 0, 0); idle();
    chk("R5 cu0", {31'd0, cp0_en_o}, 32'd1);
    chk("R6 cu1", {31'd0, fpu_en_o}, 32'd1);

    drive(1, 32'hFFFF_FFFF, 0, 0, 0, 0); idle();
    chk("R8 mask", status_o, 32'h3678_FF1F);
    chk("R4 exl kernel", {29'd0, mode_o}, 32'd1);

    drive(1, 32'h10, 0, 0, 0, 0); idle();
    drive(1, 32'h0, 1, 0, 0, 0);
    chk("R11 exc over write", status_o, 32'h12);
    idle();
    chk("R9 exc kernel", {29'd0, mode_o}, 32'd1);

    drive(1, 32'h8, 0, 0, 0, 0); idle();
    chk("R3 super again", {29'd0, mode_o}, 32'd2);
    drive(1, 32'h10, 1, 1, 0, 0);
    chk("R11 err over exc", status_o, 32'h0040_000C);
    chk("R9 pc_load", {31'd0, pc_load_o}, 32'd1);
    chk("R9 pc_vec", pc_vec_o, 32'hBFC0_0000);
    idle();
    chk("R9 pc pulse ends", {31'd0, pc_load_o}, 32'd0);
    chk("R4 erl kernel", {29'd0, mode_o}, 32'd1);

    drive(1, 32'h10, 0, 0, 0, 0); idle();
    drive(0, 0, 0, 0, 1, 0);
    chk("R9 dbg set", {31'd0, dbg_mode_o}, 32'd1);
    idle();
    chk("R9 dbg kernel", {29'd0, mode_o}, 32'd1);
    chk("R9 dbg cp0", {31'd0, cp0_en_o}, 32'd1);
    drive(0, 0, 0, 0, 0, 1); idle();
    chk("R2 user after dret", {29'd0, mode_o}, 32'd4);
    drive(0, 0, 0, 0, 1, 1);
    chk("R11 entry over ret", {31'd0, dbg_mode_o}, 32'd1);
    drive(0, 0, 0, 0, 0, 1); idle();

    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom;
      drive(r[0] | r[1], $urandom, (r[7:4] == 4'd1), (r[12:8] == 5'd3),
            (r[17:14] == 4'd2), (r[21:19] == 3'd5));
    end
    idle();
    finish_run();
  end
endmodule